// File: doc/BRIEF.md
# Encoded Prescaler Time-Base Generator

This block turns the system clock into a periodic one-cycle enable, nominally at 1 MHz, that paces the slot timers of a one-wire bus controller. The host writes one byte, the divisor code, and the block divides the clock by the product of an odd prescale and a power of two, both taken from that byte. Packing the ratio this way lets one byte cover input clocks from 1 MHz to 128 MHz. Examples are 3, 5 and 7 MHz (odd factor only), 2 through 128 MHz in powers of two, and mixed ratios such as 10, 24, 56 or 112.

The code is laid out as follows. The top bit turns the time base on. The two lowest bits pick the odd prescale 1, 3, 5 or 7. The three bits above them pick an extra divide by 2^n. The two remaining bits are spare. Every write, including a write of the value already held, restarts the division from zero. This gives software a known phase for the tick relative to the write.

Top module: `tick_timebase_gen`

## Requirements
- R1: After reset the held code is 0x00, so the time base is off and `tick` stays low until a code with bit 7 set is written.
- R2: While the held code has bit 7 clear, `tick` stays low whatever bits [6:0] hold (for example 0x1F or 0x7F).
- R3: Bits [1:0] of the code, value k, select an odd prescale of 2k+1. Codes 0x80, 0x81, 0x82 and 0x83 give tick periods of 1, 3, 5 and 7 clock cycles.
- R4: Bits [4:2] of the code, value n, select an extra divide by 2^n. Codes 0x84, 0x88, 0x8C, 0x90, 0x94, 0x98 and 0x9C give periods of 2, 4, 8, 16, 32, 64 and 128 cycles.
- R5: When both fields are non-zero the period is their product: 0x86 gives 10, 0x89 gives 12, 0x8D gives 24, 0x8F gives 56, 0x93 gives 112 and 0x9F gives 896 cycles.
- R6: For a period P, `tick` is high in the P-th clock cycle after the write edge and then once every P cycles. When P > 1 each pulse lasts exactly one cycle; when P = 1 the tick is high in every cycle.
- R7: Any write restarts the phase from zero, even a write of the code already held. The next tick comes P cycles after that write, whatever the old phase was.
- R8: Bits [6:5] of the code have no effect: 0xE6 gives the same ticks as 0x86.
- R9: A write with bit 7 clear while the time base is running stops the ticks, starting with the first cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the divisor code, sampled on the rising edge |
| cfg_data | input | 8 | Divisor code: [7] enable, [6:5] spare, [4:2] power-of-two select, [1:0] odd prescale select |
| tick | output | 1 | One-cycle time-base enable |

## Verification
The pure odd codes and the pure power-of-two codes are tried separately, so that a fault in one field decode cannot be hidden by the other. Mixed codes, up to the largest ratio of 896, then show whether the two stages multiply, or whether they only add or share one counter. Repeated writes of the same code after a window of a length that is not a multiple of the period show whether restart is a real phase reset. Codes with bit 7 clear, written after reset, after a running code and with all other bits set, show that the enable gates both counters. A code with the spare bits set, compared with its clean twin, shows that those bits are ignored.

// File: rtl/tbg_pkg.sv
// Package: shared layout of the divisor code and default field widths.
// Assumes an 8-bit code with the enable flag in the top bit.
package tbg_pkg;

    localparam int CODE_W        = 8;
    localparam int DEF_ODD_SEL_W = 2;
    localparam int DEF_POW_W     = 3;

    // Field layout of the host-written divisor code.
    typedef struct packed {
        logic       en;     // time base runs when set
        logic [1:0] spare;  // no effect
        logic [2:0] pow;    // extra divide by 2**pow
        logic [1:0] odd;    // prescale of 2*odd+1
    } tbg_code_t;

endpackage

// File: rtl/tbg_code_reg.sv
// Module: holds the divisor code last written by the host and splits it
// into its run flag and two selects. Assumes one write per strobe cycle.
module tbg_code_reg
    import tbg_pkg::*;
#(
    parameter int ODD_SEL_W = DEF_ODD_SEL_W,
    parameter int POW_W     = DEF_POW_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CODE_W-1:0]    cfg_data,
    output logic                 run,
    output logic [ODD_SEL_W-1:0] odd_sel,
    output logic [POW_W-1:0]     pow_sel
);

    tbg_code_t wr_code;
    logic      en_q;
    logic [ODD_SEL_W-1:0] odd_q;
    logic [POW_W-1:0]     pow_q;
    logic      unused_spare_bits;

    assign wr_code           = tbg_code_t'(cfg_data);
    assign unused_spare_bits = ^wr_code.spare;

    // Capture the fields of a new code; reset leaves the time base off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            odd_q <= '0;
            pow_q <= '0;
        end else if (cfg_we) begin
            en_q  <= wr_code.en;
            odd_q <= ODD_SEL_W'(wr_code.odd);
            pow_q <= POW_W'(wr_code.pow);
        end
    end

    assign run     = en_q;
    assign odd_sel = odd_q;
    assign pow_sel = pow_q;

endmodule

// File: rtl/tbg_odd_prescaler.sv
// Module: divides the clock by an odd value 2*sel+1 and emits a one-cycle
// strobe on the last count. Assumes clr is high whenever the code changes.
module tbg_odd_prescaler #(
    parameter int ODD_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 run,
    input  logic [ODD_SEL_W-1:0] odd_sel,
    output logic                 stb
);

    localparam int CNT_W = ODD_SEL_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             at_last;

    // Last count of an odd divide 2k+1 is 2k.
    assign last_cnt = {odd_sel, 1'b0};
    assign at_last  = (cnt_q == last_cnt);
    assign stb      = run && at_last;

    // Count up while running and wrap after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tbg_pow_postscaler.sv
// Module: counts prescaler strobes and passes every 2**sel-th one out as
// the tick. Assumes stb is a one-cycle pulse, cleared with the prescaler.
module tbg_pow_postscaler #(
    parameter int POW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             stb,
    input  logic [POW_W-1:0] pow_sel,
    output logic             tick
);

    localparam int CNT_W = (1 << POW_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wrap_mask;
    logic             at_wrap;

    // Low pow_sel bits set: the last count of a divide by 2**pow_sel.
    assign wrap_mask = ~({CNT_W{1'b1}} << pow_sel);
    assign at_wrap   = (cnt_q == wrap_mask);
    assign tick      = stb && at_wrap;

    // Advance once per prescaler strobe, wrapping at the mask.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (stb) begin
            cnt_q <= at_wrap ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tick_timebase_gen.sv
// Module: time-base generator for one-wire slot timing. It divides clk by
// (2*odd+1) * 2**pow from a host-written code. A write clears both stages,
// so the first tick comes one full period later. Assumes synchronous reset.
module tick_timebase_gen
    import tbg_pkg::*;
#(
    parameter int ODD_SEL_W = DEF_ODD_SEL_W,
    parameter int POW_W     = DEF_POW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_data,
    output logic              tick
);

    logic                 run;
    logic [ODD_SEL_W-1:0] odd_sel;
    logic [POW_W-1:0]     pow_sel;
    logic                 stage_clr;
    logic                 pre_stb;

    // Any write or a disabled code holds both stages at zero.
    assign stage_clr = cfg_we || !run;

    tbg_code_reg #(.ODD_SEL_W(ODD_SEL_W), .POW_W(POW_W)) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data),
        .run      (run),
        .odd_sel  (odd_sel),
        .pow_sel  (pow_sel)
    );

    tbg_odd_prescaler #(.ODD_SEL_W(ODD_SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stage_clr),
        .run     (run),
        .odd_sel (odd_sel),
        .stb     (pre_stb)
    );

    tbg_pow_postscaler #(.POW_W(POW_W)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stage_clr),
        .stb     (pre_stb),
        .pow_sel (pow_sel),
        .tick    (tick)
    );

endmodule

// File: rtl/tbg_checks.sv
// Checker: temporal properties of the time-base generator, bound to the top.
module tbg_checks
    import tbg_pkg::*;
#(
    parameter int ODD_SEL_W = DEF_ODD_SEL_W,
    parameter int POW_W     = DEF_POW_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [CODE_W-1:0]    cfg_data,
    input logic                 run,
    input logic                 pre_stb,
    input logic [ODD_SEL_W-1:0] odd_sel,
    input logic [POW_W-1:0]     pow_sel,
    input logic                 tick
);

    tbg_code_t wr_code;
    assign wr_code = tbg_code_t'(cfg_data);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !tick);

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    // R9
    stop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !wr_code.en) |=> !tick);

    // R7
    restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wr_code.en && ({wr_code.pow, wr_code.odd} != '0)) |=> !tick);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cfg_we && ({odd_sel, pow_sel} != '0)) |=> !tick);

    // R3
    pre_pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_stb && !cfg_we && (odd_sel != '0)) |=> !pre_stb);

endmodule

bind tick_timebase_gen tbg_checks #(.ODD_SEL_W(ODD_SEL_W), .POW_W(POW_W)) u_tbg_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_data (cfg_data),
    .run      (run),
    .pre_stb  (pre_stb),
    .odd_sel  (odd_sel),
    .pow_sel  (pow_sel),
    .tick     (tick)
);

// File: tb/tick_timebase_gen_tb_top.sv
// Scoreboard bench: the driver queues expected tick cycles for each code,
// and the monitor compares them with the tick output on every falling edge.
module tick_timebase_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic       tick;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_fails = 0;
    int    tick_seen = 0;
    string cur_req = "R1";
    int    exp_cyc[$];
    string exp_req[$];

    tick_timebase_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data),
        .tick     (tick)
    );

    always #5 clk = ~clk;

    // Cycle index: value N holds between rising edges N and N+1.
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop expected ticks and compare with the output.
    always @(negedge clk) begin
        if (tick) tick_seen++;
        if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
            n_checks++;
            if (!tick) begin
                n_fails++;
                $display("FAIL %s: cycle %0d tick actual=0 expected=1", exp_req[0], cyc);
            end
            void'(exp_cyc.pop_front());
            void'(exp_req.pop_front());
        end else if (tick) begin
            n_checks++;
            n_fails++;
            $display("FAIL %s: cycle %0d tick actual=1 expected=0", cur_req, cyc);
        end
    end

    // Driver: write a code, queue the expected ticks for a window, then check the count.
    task automatic run_code(input logic [7:0] code, input int len, input string req);
        int n0;
        int per;
        int n_exp;
        cfg_data = code;
        cfg_we   = 1'b1;
        @(posedge clk);
        #1;
        cfg_we    = 1'b0;
        n0        = cyc;
        cur_req   = req;
        tick_seen = 0;
        n_exp     = 0;
        per = (2 * int'(code[1:0]) + 1) << int'(code[4:2]);
        if (code[7]) begin
            for (int k = 1; n0 + k * per - 1 <= n0 + len - 1; k++) begin
                exp_cyc.push_back(n0 + k * per - 1);
                exp_req.push_back(req);
                n_exp++;
            end
        end
        repeat (len) @(negedge clk);
        #2;
        n_checks++;
        if (tick_seen != n_exp || exp_cyc.size() != 0) begin
            n_fails++;
            $display("FAIL %s: code %02h tick count actual=%0d expected=%0d", req, code, tick_seen, n_exp);
            exp_cyc.delete();
            exp_req.delete();
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        n_fails++;
        $display("FAIL watchdog: cycle actual=%0d expected=finish", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset state, no ticks before any write
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        #2;
        n_checks++;
        if (tick_seen != 0) begin
            n_fails++;
            $display("FAIL R1: ticks after reset actual=%0d expected=0", tick_seen);
        end
        // R2: bit 7 clear gives no ticks
        run_code(8'h1F, 40, "R2");
        run_code(8'h7F, 40, "R2");
        // R3: odd prescale only
        run_code(8'h80, 12, "R3");
        run_code(8'h81, 20, "R3");
        run_code(8'h82, 26, "R3");
        run_code(8'h83, 30, "R3");
        // R4: power-of-two only
        run_code(8'h84, 12, "R4");
        run_code(8'h88, 20, "R4");
        run_code(8'h8C, 40, "R4");
        run_code(8'h90, 70, "R4");
        run_code(8'h94, 100, "R4");
        run_code(8'h98, 200, "R4");
        run_code(8'h9C, 300, "R4");
        // R5: product of both fields
        run_code(8'h86, 45, "R5");
        run_code(8'h89, 50, "R5");
        run_code(8'h8D, 75, "R5");
        run_code(8'h8F, 120, "R5");
        run_code(8'h93, 240, "R5");
        run_code(8'h9F, 1900, "R5");
        // R6: first tick one period after the write, single-cycle pulses
        run_code(8'h85, 25, "R6");
        // R7: rewriting the same code restarts the phase
        run_code(8'h85, 10, "R7");
        run_code(8'h85, 10, "R7");
        run_code(8'h85, 20, "R7");
        run_code(8'h8F, 20, "R7");
        run_code(8'h83, 22, "R7");
        // R8: spare bits ignored
        run_code(8'hE6, 45, "R8");
        run_code(8'hA0, 10, "R8");
        // R9: disabling write stops a running time base
        run_code(8'h80, 8, "R9");
        run_code(8'h02, 30, "R9");
        run_code(8'h82, 16, "R9");
        run_code(8'h00, 30, "R9");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule